// File: doc/BRIEF.md
# Vectored Interrupt Controller with Mask Aliases

The block gathers up to 32 interrupt request lines into one processor interrupt. Each request is latched into a status register. A per-source enable mask selects which latched requests count as pending. Software acknowledges requests by writing a mask, and it can set or clear individual enable bits without a read-modify-write, through two alias addresses. A vector register returns the lowest-numbered pending source directly, so a handler can dispatch without scanning.

A two-bit master enable is held in a small state machine with four states. `ME_OFF` (bits 00) keeps the output low. `ME_GATE` (bits 01) opens only the output gate. `ME_ARM` (bits 10) arms only the hardware path. `ME_RUN` (bits 11) drives the output from the pending set. Every write to the master enable address moves the machine to the state named by write data bits [1:0], from any state, including the current one. When no write arrives the machine holds its state. A parameter chooses level capture or rising-edge capture for all sources.

The register bus is a single-cycle strobe interface with word addresses. A write takes effect at the clock edge where the write strobe is sampled. A read is sampled on the same kind of edge, and its data appears on `bus_rdata` one cycle later.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, the status, enable and master enable registers read zero, the vector register reads 0xFFFFFFFF, and `irq_out` is low.
- R2: The status register (word address 0) latches requests whatever the enable bits hold. The pending register (word address 1) reads status AND enable.
- R3: A write to the enable register (word address 2) replaces the whole mask. Writing zero removes every source from pending, and `irq_out` goes low.
- R4: A write to the set-enable alias (word address 4) sets each enable bit written as 1 and leaves every other enable bit unchanged.
- R5: A write to the clear-enable alias (word address 5) clears each enable bit written as 1 and leaves every other enable bit unchanged.
- R6: A write to the acknowledge alias (word address 3) clears each status bit written as 1 and leaves bits written as 0 unchanged. In level mode, a source still asserted during the acknowledge cycle stays latched.
- R7: The vector register (word address 6) returns the lowest index among pending sources, zero-extended. When nothing is pending it reads 0xFFFFFFFF.
- R8: `irq_out` is high only when master enable bits [1:0] are both 1 (written to word address 7) and at least one pending bit is set. The value 1, 2 or 0 keeps it low.
- R9: The acknowledge, set-enable and clear-enable aliases read zero. Writes to the status, pending and vector addresses change nothing.
- R10: In edge mode only a 0-to-1 transition of a source latches it. An acknowledge clears the bit even while the source stays high. A rising edge in the same cycle as an acknowledge of that bit leaves it latched.
- R11: Source n occupies bit n of every mask register, so bit 31 selects source 31 and the vector reads 31 for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data follows one cycle later |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_src | input | 32 | Interrupt request lines, bit n is source n |
| irq_out | output | 1 | Combined interrupt to the processor |

## Verification
The bench targets four behaviours:
- Acknowledging a level source that is still held high. A design that cleared the bit unconditionally would lose a request that is still active.
- A rising edge that arrives in the same cycle as an acknowledge of the same bit in edge mode. Applying the clear after the set would silently drop that interrupt.
- Partial master enable values 1 and 2. A design that ORed the two bits would raise the interrupt early.
- Priority ties, together with source 31 and the empty case of the vector. An off-by-one or highest-first encoder would return the wrong index there, and so would a vector that read zero when nothing was pending.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_STAT = 3'd0,
        A_PEND = 3'd1,
        A_ENAB = 3'd2,
        A_ACK  = 3'd3,
        A_SETE = 3'd4,
        A_CLRE = 3'd5,
        A_VEC  = 3'd6,
        A_MEN  = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        ME_OFF  = 2'b00,
        ME_GATE = 2'b01,
        ME_ARM  = 2'b10,
        ME_RUN  = 2'b11
    } me_state_e;

endpackage

// File: rtl/vic_capture.sv
module vic_capture #(
    parameter int N_SRC     = 32,
    parameter bit EDGE_MODE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src,
    input  logic [N_SRC-1:0] ack,
    output logic [N_SRC-1:0] status
);

    logic [N_SRC-1:0] set_v;

    generate
        if (EDGE_MODE) begin : g_edge
            logic [N_SRC-1:0] src_q;
            always_ff @(posedge clk) begin
                if (!rst_n) src_q <= '0;
                else        src_q <= src;
            end
            assign set_v = src & ~src_q;
        end else begin : g_level
            assign set_v = src;
        end
    endgenerate

    // Clear first, then set: a new request wins over a same-cycle acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~ack) | set_v;
    end

    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(set_v)) == $past(set_v)));

    p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(ack & ~set_v)) == '0));

endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
    parameter int N_SRC = 32,
    localparam int IW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] pend,
    output logic             any,
    output logic [IW-1:0]    idx
);

    always_comb begin
        idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend[i]) idx = IW'(i);
        end
    end

    assign any = |pend;

    p_vec_pick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (pend[idx] && ((pend & ((N_SRC'(1) << idx) - N_SRC'(1))) == '0)));

endmodule

// File: rtl/vic_mstr.sv
module vic_mstr
    import vic_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       men_wr,
    input  logic [1:0] men_bits,
    input  logic       any_pend,
    output logic [1:0] me_rd,
    output logic       irq_o
);

    me_state_e state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ME_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ME_OFF:  if (men_wr) nxt = me_state_e'(men_bits);
            ME_GATE: if (men_wr) nxt = me_state_e'(men_bits);
            ME_ARM:  if (men_wr) nxt = me_state_e'(men_bits);
            ME_RUN:  if (men_wr) nxt = me_state_e'(men_bits);
        endcase
    end

    always_comb begin
        unique case (state)
            ME_OFF:  begin me_rd = 2'b00; irq_o = 1'b0;     end
            ME_GATE: begin me_rd = 2'b01; irq_o = 1'b0;     end
            ME_ARM:  begin me_rd = 2'b10; irq_o = 1'b0;     end
            ME_RUN:  begin me_rd = 2'b11; irq_o = any_pend; end
        endcase
    end

    p_gate_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (state == ME_RUN));

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import vic_pkg::*;
#(
    parameter int N_SRC     = 32,
    parameter int DW        = 32,
    parameter bit EDGE_MODE = 1'b0,
    localparam int IW       = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [N_SRC-1:0]  irq_src,
    output logic              irq_out
);

    reg_sel_e         sel;
    logic [N_SRC-1:0] wmask;
    logic [N_SRC-1:0] enable;
    logic [N_SRC-1:0] status;
    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] ack;
    logic             any;
    logic [IW-1:0]    idx;
    logic [1:0]       me_rd;

    assign sel   = reg_sel_e'(bus_addr);
    assign wmask = bus_wdata[N_SRC-1:0];
    assign ack   = (bus_wr && sel == A_ACK) ? wmask : '0;
    assign pend  = status & enable;

    vic_capture #(.N_SRC(N_SRC), .EDGE_MODE(EDGE_MODE)) u_cap (
        .clk(clk), .rst_n(rst_n), .src(irq_src), .ack(ack), .status(status)
    );

    vic_prio #(.N_SRC(N_SRC)) u_prio (
        .clk(clk), .rst_n(rst_n), .pend(pend), .any(any), .idx(idx)
    );

    vic_mstr u_mstr (
        .clk(clk), .rst_n(rst_n),
        .men_wr(bus_wr && sel == A_MEN), .men_bits(bus_wdata[1:0]),
        .any_pend(any), .me_rd(me_rd), .irq_o(irq_out)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= '0;
        end else if (bus_wr) begin
            unique case (sel)
                A_ENAB:  enable <= wmask;
                A_SETE:  enable <= enable | wmask;
                A_CLRE:  enable <= enable & ~wmask;
                default: enable <= enable;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            unique case (sel)
                A_STAT: bus_rdata <= DW'(status);
                A_PEND: bus_rdata <= DW'(pend);
                A_ENAB: bus_rdata <= DW'(enable);
                A_ACK:  bus_rdata <= '0;
                A_SETE: bus_rdata <= '0;
                A_CLRE: bus_rdata <= '0;
                A_VEC:  bus_rdata <= any ? DW'(idx) : '1;
                A_MEN:  bus_rdata <= DW'(me_rd);
            endcase
        end
    end

    p_enab_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == A_ENAB && wmask == '0) |=> !irq_out);

    p_set_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == A_SETE) |=>
            (((enable & $past(wmask)) == $past(wmask)) &&
             ((enable & ~$past(wmask)) == ($past(enable) & ~$past(wmask)))));

    p_clr_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == A_CLRE) |=>
            (((enable & $past(wmask)) == '0) &&
             ((enable & ~$past(wmask)) == ($past(enable) & ~$past(wmask)))));

    p_irq_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((status & enable) != '0));

    p_alias_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (sel == A_ACK || sel == A_SETE || sel == A_CLRE)) |=> (bus_rdata == '0));

endmodule

// File: tb/tb_vec_irq_ctrl.sv
`timescale 1ns/1ps
module tb_vec_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata_l, rdata_e;
    logic [31:0] src_l = '0;
    logic [31:0] src_e = '0;
    logic        irq_l, irq_e;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    vec_irq_ctrl #(.EDGE_MODE(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_l),
        .irq_src(src_l), .irq_out(irq_l)
    );

    vec_irq_ctrl #(.EDGE_MODE(1'b1)) dut_edge (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_e),
        .irq_src(src_e), .irq_out(irq_e)
    );

    typedef struct {
        logic [31:0] exp;
        bit          edge_dut;
        string       tag;
    } item_t;

    item_t sb[$];
    logic  rd_q = 1'b0;

    always @(posedge clk) rd_q <= bus_rd;

    // Monitor: pops one expected item for every read sampled at the last edge.
    always @(negedge clk) begin
        if (rd_q) begin
            if (sb.size() == 0) begin
                total++; bad++;
                $display("FAIL scoreboard: read data with no expected item");
            end else begin
                item_t it;
                logic [31:0] got;
                it  = sb.pop_front();
                got = it.edge_dut ? rdata_e : rdata_l;
                total++;
                if (got !== it.exp) begin
                    bad++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, got, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input bit e, input string tag);
        item_t it;
        it.exp = exp; it.edge_dut = e; it.tag = tag;
        sb.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk_irq(input logic got, input logic exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, got, exp);
        end
    endtask

    localparam logic [2:0] STAT = 3'd0, PEND = 3'd1, ENAB = 3'd2, ACK = 3'd3,
                           SETE = 3'd4, CLRE = 3'd5, VEC = 3'd6, MEN = 3'd7;

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(STAT, 32'h0, 0, "R1 status");
        rd(ENAB, 32'h0, 0, "R1 enable");
        rd(MEN,  32'h0, 0, "R1 master");
        rd(VEC,  32'hFFFF_FFFF, 0, "R1 vector");
        chk_irq(irq_l, 1'b0, "R1 irq");

        // R2 capture without enable
        src_l = 32'h0000_0110;
        @(negedge clk);
        rd(STAT, 32'h0000_0110, 0, "R2 status");
        rd(PEND, 32'h0, 0, "R2 pending");
        rd(VEC,  32'hFFFF_FFFF, 0, "R7 empty vector");

        wr(ENAB, 32'h0000_0100);
        rd(PEND, 32'h0000_0100, 0, "R2 pending and");
        rd(VEC,  32'd8, 0, "R7 single");

        // R8 master enable states
        wr(MEN, 32'h1);
        chk_irq(irq_l, 1'b0, "R8 gate only");
        wr(MEN, 32'h2);
        chk_irq(irq_l, 1'b0, "R8 arm only");
        wr(MEN, 32'h3);
        chk_irq(irq_l, 1'b1, "R8 run");
        rd(MEN, 32'h3, 0, "R8 readback");

        // R4 / R5 aliases, R7 lowest wins
        wr(SETE, 32'h0000_0010);
        rd(ENAB, 32'h0000_0110, 0, "R4 set alias");
        rd(VEC,  32'd4, 0, "R7 lowest");
        wr(CLRE, 32'h0000_0010);
        rd(ENAB, 32'h0000_0100, 0, "R5 clear alias");

        // R9 alias reads and ignored writes
        rd(ACK,  32'h0, 0, "R9 ack reads zero");
        rd(SETE, 32'h0, 0, "R9 set reads zero");
        rd(CLRE, 32'h0, 0, "R9 clear reads zero");
        wr(STAT, 32'hFFFF_FFFF);
        wr(PEND, 32'h0);
        wr(VEC,  32'h0);
        rd(STAT, 32'h0000_0110, 0, "R9 status write ignored");
        rd(ENAB, 32'h0000_0100, 0, "R9 enable untouched");

        // R6 acknowledge in level mode
        wr(ACK, 32'h0000_0110);
        rd(STAT, 32'h0000_0110, 0, "R6 level held");
        src_l = 32'h0;
        wr(ACK, 32'h0000_0100);
        rd(STAT, 32'h0000_0010, 0, "R6 masked ack");
        chk_irq(irq_l, 1'b0, "R6 irq after ack");
        wr(ACK, 32'hFFFF_FFFF);
        rd(STAT, 32'h0, 0, "R6 ack all");

        // R3 full enable write of zero
        src_l = 32'h0000_0001;
        wr(ENAB, 32'hFFFF_FFFF);
        chk_irq(irq_l, 1'b1, "R3 all enabled");
        wr(ENAB, 32'h0);
        chk_irq(irq_l, 1'b0, "R3 zero disables");
        rd(PEND, 32'h0, 0, "R3 pending empty");
        src_l = 32'h0;
        wr(ACK, 32'hFFFF_FFFF);

        // R11 top bit
        src_l = 32'h8000_0000;
        wr(ENAB, 32'h8000_0000);
        rd(VEC, 32'd31, 0, "R11 source 31");
        src_l = 32'h0;
        wr(ACK, 32'hFFFF_FFFF);
        rd(VEC, 32'hFFFF_FFFF, 0, "R7 empty again");

        // R10 edge mode
        src_e = 32'h0000_0008;
        @(negedge clk);
        @(negedge clk);
        rd(STAT, 32'h0000_0008, 1, "R10 edge latched");
        wr(ACK, 32'h0000_0008);
        rd(STAT, 32'h0, 1, "R10 ack with source high");
        src_e = 32'h0000_0028;
        wr(ACK, 32'h0000_0020);
        rd(STAT, 32'h0000_0020, 1, "R10 edge beats ack");

        repeat (4) @(negedge clk);
        if (sb.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard: actual=%0d left expected=0", sb.size());
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule